// File: doc/BRIEF.md
# Indexed codec control register file

This block is the device-side register front end of an audio codec. A host reaches it through four byte-wide ports on a small synchronous bus. Port 0 selects a register and carries a mode-change-enable flag. Port 1 reads or writes the register that port 0 selects. Port 2 holds the interrupt flag. Port 3 is a polled port that is not used here. Behind port 1 sits a bank of indirect configuration registers. Some of their bits are hardwired so that host software can identify the part and its revision.

The bank runs in one of two modes. In legacy mode only sixteen registers exist, and indices 16 to 31 fold back onto 0 to 15. Setting the extended-mode bit in register 12 exposes the upper registers as separate storage. The block passes the mode-change-enable flag and the interface configuration register (index 9) to the codec's sequencer. From that sequencer it takes a busy indication and interrupt events.

Top module: `codec_regfile`

## Requirements
- R1: After reset, the index port holds index 0 with mode-change-enable clear, and the interrupt flag is 0. The indirect registers 0..15 hold 08,08,08,08,08,08,00,00,00,08,02,00,CA,00,00,00 (hex), which leaves extended mode on. Extended registers hold 00.
- R2: A write to port 0 stores the register number from bits 4:0 and mode-change-enable from bit 6. While idle, a read of port 0 returns those bits with bits 7 and 5 as 0. `mce_out` follows bit 6.
- R3: While `busy_in` is high, a read of port 0 returns exactly 0x80.
- R4: Port 1 reads and writes the register selected by port 0. `iface_cfg` always shows register 9.
- R5: In legacy mode (register 12 bit 6 = 0), an access to index i+16 reaches the same storage as index i.
- R6: In extended mode (register 12 bit 6 = 1), indices 16..16+EXT_COUNT-1 are separate registers, so a write to register 0 leaves register 16 unchanged.
- R7: Register 12 bits 3:0 always read the revision code REV_CODE (default 0xA) and bit 7 always reads 1. Writes to these bits are ignored. Bits 6:4 are writable.
- R8: Bit 4 of registers 0 and 1 always reads 0, and writes to it are ignored.
- R9: In extended mode, indices at or above 16+EXT_COUNT (28..31 by default) read 0x00, and writes to them change no register.
- R10: Bit 0 of port 2 is the interrupt flag. A pulse on `irq_set` sets it, and any write to port 2 clears it. When both happen in the same cycle, the set wins.
- R11: Port 3 reads 0x00, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Port select (0 index, 1 data, 2 status, 3 polled) |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_rdata | output | 8 | Read data, 0 when no read is in progress |
| busy_in | input | 1 | Sequencer is initializing or resynchronizing |
| irq_set | input | 1 | Interrupt event from the sequencer |
| irq_flag | output | 1 | Current interrupt flag |
| mce_out | output | 1 | Mode-change-enable flag |
| iface_cfg | output | 8 | Contents of interface configuration register 9 |

## Verification
Writes and reads walk the bank in both modes. An index is written through its alias and read back through its base, and the other way round. This separates real aliasing from separate storage. Write patterns with alternating bits and all ones show masked bits apart from writable ones in registers 0, 1 and 12. Accesses to unmapped indices are followed by reads of the register they would alias in legacy mode, which shows that nothing was touched. Directed cases cover the busy readback, a status clear against a simultaneous interrupt, and a reset in the middle of the run.

// File: rtl/codec_reg_pkg.sv
// Package: shared constants and per-register attribute functions for the
// indexed codec register file. Assumes at most 32 indirect indices.
package codec_reg_pkg;

    localparam int IDX_W    = 5;
    localparam int BASE_CNT = 16;

    // Reset value of each indirect register (unlisted indices reset to 0).
    function automatic logic [7:0] reg_default(input int i);
        case (i)
            0, 1, 2, 3, 4, 5, 9: reg_default = 8'h08;
            10:                  reg_default = 8'h02;
            12:                  reg_default = 8'hCA;
            default:             reg_default = 8'h00;
        endcase
    endfunction

    // Bits the host may change in each register.
    function automatic logic [7:0] reg_wmask(input int i);
        case (i)
            0, 1:    reg_wmask = 8'hEF;
            12:      reg_wmask = 8'h70;
            default: reg_wmask = 8'hFF;
        endcase
    endfunction

    // Hardwired bits seen on read (identification and revision).
    function automatic logic [7:0] reg_fixed(input int i, input logic [3:0] rev);
        if (i == 12) reg_fixed = {4'h8, rev};
        else         reg_fixed = 8'h00;
    endfunction

endpackage

// File: rtl/idx_port.sv
// Index port: holds the selected register number and the mode-change-enable
// flag. Assumes one write strobe per access; busy overrides the read value.
module idx_port
    import codec_reg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wdata,
    input  logic             busy,
    output logic [7:0]       rd_val,
    output logic [IDX_W-1:0] idx,
    output logic             mce
);
    logic [7:0] idx_q;

    // Capture the register number and flag, dropping bits 7 and 5.
    always_ff @(posedge clk) begin
        if (!rst_n)     idx_q <= 8'h00;
        else if (wr_en) idx_q <= wdata & 8'h5F;
    end

    // Busy readback takes precedence over the stored value.
    always_comb begin
        rd_val = busy ? 8'h80 : idx_q;
    end

    assign idx = idx_q[IDX_W-1:0];
    assign mce = idx_q[6];

    // R2: a port write lands in the flag on the next cycle
    a_r2_mce_capture: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mce == $past(wdata[6])) && (idx == $past(wdata[4:0])));

endmodule

// File: rtl/stat_port.sv
// Status port: one interrupt flag, set by sequencer events and cleared by any
// host write. Assumes set and clear may coincide; set then wins.
module stat_port (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Keep the flag; a new event outranks a host clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    // R10: an event always leaves the flag set
    a_r10_set: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
    // R10: a lone clear always leaves the flag low
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);

endmodule

// File: rtl/ireg_bank.sv
// Indirect register bank: 16 base registers plus EXT_COUNT extended ones.
// In legacy mode the upper index bit is ignored (aliasing); in extended mode
// indices past the bank are unmapped. Read-only bits come from the package.
module ireg_bank
    import codec_reg_pkg::*;
#(
    parameter int         EXT_COUNT = 12,
    parameter logic [3:0] REV_CODE  = 4'hA
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       rd_val,
    output logic             mode2,
    output logic [7:0]       cfg
);
    localparam int NREG = BASE_CNT + EXT_COUNT;

    logic [7:0]       store [NREG];
    logic [IDX_W-1:0] eff;
    logic             hit;

    // Fold the index in legacy mode and decide whether it is mapped.
    always_comb begin
        eff = mode2 ? idx : {1'b0, idx[IDX_W-2:0]};
        hit = (int'(eff) < NREG);
    end

    // One storage byte per register; only writable bits are kept.
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                store[g] <= reg_default(g) & reg_wmask(g);
            else if (wr_en && hit && (int'(eff) == g))
                store[g] <= wdata & reg_wmask(g);
        end
    end

    // Merge stored and hardwired bits; unmapped indices read zero.
    always_comb begin
        if (hit) rd_val = (store[eff] & reg_wmask(int'(eff))) | reg_fixed(int'(eff), REV_CODE);
        else     rd_val = 8'h00;
    end

    assign mode2 = store[12][6];
    assign cfg   = store[9];

    // R8: volume registers never store bit 4
    a_r8_bit4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (store[0][4] == 1'b0) && (store[1][4] == 1'b0));

endmodule

// File: rtl/codec_regfile.sv
// Top: decodes the four host ports onto the index port, indirect bank and
// status flag, and exports the flag, mode-change-enable and register 9.
// Assumes reads are combinational and strobes last one cycle.
module codec_regfile
    import codec_reg_pkg::*;
#(
    parameter int         EXT_COUNT = 12,
    parameter logic [3:0] REV_CODE  = 4'hA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_wr,
    input  logic       bus_rd,
    output logic [7:0] bus_rdata,
    input  logic       busy_in,
    input  logic       irq_set,
    output logic       irq_flag,
    output logic       mce_out,
    output logic [7:0] iface_cfg
);
    localparam logic [1:0] P_IDX  = 2'd0;
    localparam logic [1:0] P_DATA = 2'd1;
    localparam logic [1:0] P_STAT = 2'd2;

    logic [7:0]       idx_rd, bank_rd;
    logic [IDX_W-1:0] idx;
    logic             mode2;
    logic             wr_idx, wr_data, wr_stat;

    // Route the write strobe to the addressed port.
    always_comb begin
        wr_idx  = bus_wr && (bus_addr == P_IDX);
        wr_data = bus_wr && (bus_addr == P_DATA);
        wr_stat = bus_wr && (bus_addr == P_STAT);
    end

    idx_port u_idx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_idx), .wdata(bus_wdata),
        .busy(busy_in), .rd_val(idx_rd), .idx(idx), .mce(mce_out)
    );

    ireg_bank #(.EXT_COUNT(EXT_COUNT), .REV_CODE(REV_CODE)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_data), .idx(idx),
        .wdata(bus_wdata), .rd_val(bank_rd), .mode2(mode2), .cfg(iface_cfg)
    );

    stat_port u_stat (
        .clk(clk), .rst_n(rst_n), .set(irq_set), .clr(wr_stat), .flag(irq_flag)
    );

    // Select the read source; port 3 and idle cycles return zero.
    always_comb begin
        bus_rdata = 8'h00;
        if (bus_rd) begin
            case (bus_addr)
                P_IDX:   bus_rdata = idx_rd;
                P_DATA:  bus_rdata = bank_rd;
                P_STAT:  bus_rdata = {7'b0, irq_flag};
                default: bus_rdata = 8'h00;
            endcase
        end
    end

    // R3: busy readback is exactly 0x80
    a_r3_busy_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == P_IDX && busy_in) |-> (bus_rdata == 8'h80));

    // R7: identification bits of register 12 always visible
    a_r7_ident: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == P_DATA && idx[3:0] == 4'd12 && (!mode2 || !idx[4]))
        |-> (bus_rdata[7] && bus_rdata[3:0] == REV_CODE));

    // R4: a data write to register 9 reaches the exported configuration
    a_r4_cfg_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && idx[3:0] == 4'd9 && (!mode2 || !idx[4]))
        |=> (iface_cfg == $past(bus_wdata)));

    // R11: polled port reads zero
    a_r11_polled: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd3) |-> (bus_rdata == 8'h00));

endmodule

// File: tb/codec_regfile_tb.sv
module codec_regfile_tb;

    typedef struct packed {
        logic       wr;
        logic [1:0] a;
        logic [7:0] d;
        logic [3:0] r;
    } vec_t;

    localparam int NV = 41;
    // wr=1: write d to port a; wr=0: read port a, expect d; r = requirement.
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd0, 8'h0C, 4'd2},  // select reg 12 (R2)
        '{1'b0, 2'd0, 8'h0C, 4'd2},
        '{1'b0, 2'd1, 8'hCA, 4'd1},  // reset value, ext mode on (R1)
        '{1'b1, 2'd1, 8'h35, 4'd7},  // RO nibble ignored, mode2 off (R7)
        '{1'b0, 2'd1, 8'hBA, 4'd7},
        '{1'b1, 2'd0, 8'h00, 4'd8},
        '{1'b1, 2'd1, 8'h5A, 4'd8},  // bit 4 dropped (R8)
        '{1'b0, 2'd1, 8'h4A, 4'd8},
        '{1'b1, 2'd0, 8'h10, 4'd5},  // index 16 aliases 0 (R5)
        '{1'b0, 2'd1, 8'h4A, 4'd5},
        '{1'b1, 2'd1, 8'h21, 4'd5},
        '{1'b1, 2'd0, 8'h00, 4'd5},
        '{1'b0, 2'd1, 8'h21, 4'd5},
        '{1'b1, 2'd0, 8'h4C, 4'd2},  // mce set, reg 12
        '{1'b0, 2'd0, 8'h4C, 4'd2},
        '{1'b1, 2'd1, 8'h40, 4'd6},  // back to extended mode (R6)
        '{1'b0, 2'd1, 8'hCA, 4'd7},
        '{1'b1, 2'd0, 8'h10, 4'd6},
        '{1'b1, 2'd1, 8'h00, 4'd6},
        '{1'b1, 2'd0, 8'h00, 4'd6},
        '{1'b1, 2'd1, 8'h45, 4'd6},
        '{1'b1, 2'd0, 8'h10, 4'd6},
        '{1'b0, 2'd1, 8'h00, 4'd6},  // reg 16 untouched (R6)
        '{1'b1, 2'd0, 8'h00, 4'd6},
        '{1'b0, 2'd1, 8'h45, 4'd6},
        '{1'b1, 2'd0, 8'h1D, 4'd9},  // index 29 unmapped (R9)
        '{1'b1, 2'd1, 8'h77, 4'd9},
        '{1'b0, 2'd1, 8'h00, 4'd9},
        '{1'b1, 2'd0, 8'h0D, 4'd9},
        '{1'b0, 2'd1, 8'h00, 4'd9},  // reg 13 not hit (R9)
        '{1'b1, 2'd0, 8'h09, 4'd4},
        '{1'b1, 2'd1, 8'h0E, 4'd4},  // R4
        '{1'b0, 2'd1, 8'h0E, 4'd4},
        '{1'b1, 2'd3, 8'hFF, 4'd11}, // R11
        '{1'b0, 2'd3, 8'h00, 4'd11},
        '{1'b0, 2'd1, 8'h0E, 4'd11},
        '{1'b1, 2'd0, 8'h1B, 4'd6},  // last mapped extended index
        '{1'b1, 2'd1, 8'h99, 4'd6},
        '{1'b0, 2'd1, 8'h99, 4'd6},
        '{1'b1, 2'd0, 8'h0B, 4'd6},
        '{1'b0, 2'd1, 8'h00, 4'd6}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, busy_in = 1'b0, irq_set = 1'b0;
    logic [7:0] bus_rdata, iface_cfg;
    logic       irq_flag, mce_out;
    int         total = 0, bad = 0;
    logic       done = 1'b0;

    always #10 clk = ~clk;

    codec_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .busy_in(busy_in), .irq_set(irq_set), .irq_flag(irq_flag),
        .mce_out(mce_out), .iface_cfg(iface_cfg)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 v = bus_rdata;
        bus_rd = 1'b0;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(2'd0, v);                check("R1 index", v, 8'h00);
        rd(2'd2, v);                check("R1 status", v, 8'h00);
        check("R1 cfg", iface_cfg, 8'h08);
        check("R1 mce", {7'b0, mce_out}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) wr(VEC[i].a, VEC[i].d);
            else begin
                rd(VEC[i].a, v);
                check($sformatf("R%0d vec%0d", VEC[i].r, i), v, VEC[i].d);
            end
        end
        check("R4 cfg out", iface_cfg, 8'h0E);
        check("R2 mce out", {7'b0, mce_out}, 8'h00);

        // R3: busy readback
        @(negedge clk) busy_in = 1'b1;
        rd(2'd0, v);                check("R3 busy", v, 8'h80);
        @(negedge clk) busy_in = 1'b0;
        rd(2'd0, v);                check("R3 idle", v, 8'h0B);

        // R10: set, clear, coincident set and clear
        @(negedge clk) irq_set = 1'b1;
        @(negedge clk) irq_set = 1'b0;
        rd(2'd2, v);                check("R10 set", v, 8'h01);
        wr(2'd2, 8'h00);
        rd(2'd2, v);                check("R10 clear", v, 8'h00);
        @(negedge clk);
        bus_addr = 2'd2; bus_wr = 1'b1; irq_set = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; irq_set = 1'b0;
        check("R10 set wins", {7'b0, irq_flag}, 8'h01);

        // R1: reset mid-run restores defaults
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        check("R1 rerun cfg", iface_cfg, 8'h08);
        check("R1 rerun irq", {7'b0, irq_flag}, 8'h00);
        rd(2'd0, v);                check("R1 rerun index", v, 8'h00);
        rd(2'd1, v);                check("R1 rerun reg0", v, 8'h08);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule